// File: doc/BRIEF.md
# Mid-Bit Sampling Serial Byte Receiver

This block turns an asynchronous serial line into bytes. A frame is one low start bit, eight data bits least significant first, and one high stop bit, at a bit rate fixed at build time by a clocks-per-bit parameter. The line first goes through a two-stage synchronizer. A controller then waits for a high-to-low transition. It times half a bit period to reach the centre of the start bit, and after that samples once per full bit period. Each sample is pushed into a ten-bit shift register that collects the start bit, the data bits and the stop bit together.

The start bit is checked at its centre. If the line is high there, the event is taken as noise: a one-cycle glitch pulse is raised and the controller goes back to waiting. After the tenth sample, the middle eight register bits go into a held output register. A one-cycle done pulse is raised, and a framing-error flag is set if the end bits of the register are not a low start and a high stop. Byte and flag then stay unchanged until the next accepted frame.

Top module: `uart_midbit_rx`

## Requirements
- R1: While reset is asserted and on the first cycle after it, rx_byte is 0x00 and rx_done, rx_frame_err and rx_glitch are 0.
- R2: For a valid frame, rx_byte equals the eight data bits. The first data bit after the start bit is bit 0 of the byte.
- R3: Each accepted frame raises rx_done for exactly one clock cycle. rx_byte and rx_frame_err take their new values in that same cycle.
- R4: rx_byte changes only in a cycle where rx_done is high. It holds its value while later frames are being received.
- R5: A frame whose stop bit is sampled low is still delivered with its data byte, and rx_frame_err is 1 during that rx_done.
- R6: rx_frame_err changes only together with rx_done. A correctly framed frame clears it.
- R7: A low pulse on the line that is shorter than half a bit period raises rx_glitch for one cycle. It produces no rx_done and leaves rx_byte unchanged.
- R8: Frames sent back to back, with the next start bit right after a one-bit stop, are all received.
- R9: Reception starts only on a high-to-low transition. A line held low for several frame times yields exactly one frame, with byte 0x00 and rx_frame_err set, and nothing more until the line has been high and falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_serial | input | 1 | Asynchronous serial input line, idle high |
| rx_byte | output | 8 | Last received data byte, held |
| rx_done | output | 1 | One-cycle pulse when a frame is delivered |
| rx_frame_err | output | 1 | Stop or start bit wrong in the last delivered frame |
| rx_glitch | output | 1 | One-cycle pulse when a start edge proves to be noise |

## Verification
Two cases are hard to reach from the ports: the rejected start and the line stuck low. The rejected start needs a low pulse that ends well before the start-bit centre, so the bench drives a ten-cycle low pulse between two frames. It then checks that rx_glitch was raised, that no done pulse appeared and that the held byte did not change. For the stuck-low case, the bench holds the line low for three full frame times. The scoreboard must then receive exactly one zero byte marked with a framing error, and no further frames once the line has returned high.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HALF = 2'd1,
    ST_BITS = 2'd2,
    ST_LOAD = 2'd3
  } rx_state_t;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
  parameter int CLKS_PER_BIT = 87
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic half_sel,
  output logic tc
);
  localparam int HALF_BIT = CLKS_PER_BIT / 2;
  localparam int CNT_W    = $clog2(CLKS_PER_BIT + 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(CLKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_BIT - 1);

  logic [CNT_W-1:0] cnt;

  always_comb tc = !clr && (cnt == (half_sel ? HALF_LAST : FULL_LAST));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (tc)    cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL_LAST); // R2
endmodule

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 87,
  parameter int DATA_BITS    = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic line,
  input  logic fall,
  output logic shift_stb,
  output logic load_stb,
  output logic glitch_stb
);
  localparam int FRAME_BITS = DATA_BITS + 2;
  localparam int SH_W       = $clog2(FRAME_BITS + 1);
  localparam logic [SH_W-1:0] LAST_SHIFT = SH_W'(FRAME_BITS - 1);

  rx_state_t        state;
  logic [SH_W-1:0]  shifts;
  logic             tmr_clr, tmr_half, tmr_tc;

  rx_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .clr      (tmr_clr),
    .half_sel (tmr_half),
    .tc       (tmr_tc)
  );

  always_comb begin
    tmr_clr    = (state == ST_IDLE) || (state == ST_LOAD);
    tmr_half   = (state == ST_HALF);
    shift_stb  = ((state == ST_HALF) && tmr_tc && !line) ||
                 ((state == ST_BITS) && tmr_tc);
    glitch_stb = (state == ST_HALF) && tmr_tc && line;
    load_stb   = (state == ST_LOAD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      shifts <= '0;
    end else begin
      if (state == ST_IDLE) shifts <= '0;
      else if (shift_stb)   shifts <= shifts + 1'b1;
      case (state)
        ST_IDLE: if (fall) state <= ST_HALF;
        ST_HALF: if (tmr_tc) state <= line ? ST_IDLE : ST_BITS;
        ST_BITS: if (tmr_tc && shifts == LAST_SHIFT) state <= ST_LOAD;
        ST_LOAD: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_SHIFT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    shifts <= SH_W'(FRAME_BITS)); // R2
  AST_LOAD_FULL_FRAME: assert property (@(posedge clk) disable iff (rst)
    load_stb |-> shifts == SH_W'(FRAME_BITS)); // R2
  AST_GLITCH_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
    glitch_stb |=> (state == ST_IDLE) && (shifts == '0)); // R7
endmodule

// File: rtl/uart_midbit_rx.sv
module uart_midbit_rx #(
  parameter int CLKS_PER_BIT = 87,
  parameter int DATA_BITS    = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_serial,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 rx_done,
  output logic                 rx_frame_err,
  output logic                 rx_glitch
);
  localparam int FRAME_BITS = DATA_BITS + 2;

  logic                  line, line_d, fall;
  logic                  shift_stb, load_stb, glitch_stb;
  logic [FRAME_BITS-1:0] frame_sr;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (rx_serial),
    .d_sync  (line)
  );

  always_ff @(posedge clk) begin
    if (rst) line_d <= 1'b1;
    else     line_d <= line;
  end
  assign fall = line_d & ~line;

  rx_ctrl #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_BITS(DATA_BITS)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .line       (line),
    .fall       (fall),
    .shift_stb  (shift_stb),
    .load_stb   (load_stb),
    .glitch_stb (glitch_stb)
  );

  always_ff @(posedge clk) begin
    if (rst)            frame_sr <= '1;
    else if (shift_stb) frame_sr <= {line, frame_sr[FRAME_BITS-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_byte      <= '0;
      rx_done      <= 1'b0;
      rx_frame_err <= 1'b0;
      rx_glitch    <= 1'b0;
    end else begin
      rx_done   <= load_stb;
      rx_glitch <= glitch_stb;
      if (load_stb) begin
        rx_byte      <= frame_sr[FRAME_BITS-2:1];
        rx_frame_err <= frame_sr[0] | ~frame_sr[FRAME_BITS-1];
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> !rx_done); // R3
  AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_byte) |-> rx_done); // R4
  AST_FERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_frame_err) |-> rx_done); // R6
  AST_GLITCH_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    rx_glitch |-> !rx_done); // R7
endmodule

// File: tb/sim_uart_midbit_rx.sv
module sim_uart_midbit_rx;
  localparam int CPB = 87;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_serial = 1'b1;
  logic [7:0] rx_byte;
  logic       rx_done, rx_frame_err, rx_glitch;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int glitch_cnt = 0;
  logic [8:0] exp_q[$];
  logic [7:0] held_byte = 8'h00;
  logic       prev_done = 1'b0;
  bit         finished = 1'b0;

  always #10 clk = ~clk;

  uart_midbit_rx u0 (
    .clk          (clk),
    .rst          (rst),
    .rx_serial    (rx_serial),
    .rx_byte      (rx_byte),
    .rx_done      (rx_done),
    .rx_frame_err (rx_frame_err),
    .rx_glitch    (rx_glitch)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic line_for(input logic v, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk);
      rx_serial <= v;
    end
  endtask

  // Driver: pushes the expected result, then sends the frame.
  task automatic send_frame(input logic [7:0] d, input logic stop);
    exp_q.push_back({~stop, d});
    line_for(1'b0, CPB);
    for (int b = 0; b < 8; b++) line_for(d[b], CPB);
    line_for(stop, CPB);
  endtask

  // Monitor: pops and compares on every done, and watches width and hold.
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (prev_done && rx_done) begin
        errors++;
        $display("FAIL R3 done wider than one cycle actual=%0d expected=%0d", 1, 0);
      end
      if (!rx_done && rx_byte !== held_byte) begin
        errors++;
        $display("FAIL R4 byte changed without done actual=%0h expected=%0h", rx_byte, held_byte);
      end
      if (rx_glitch) glitch_cnt++;
      if (rx_done) begin
        done_cnt++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 R9 unexpected done", rx_byte, 0);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk(rx_byte === e[7:0], "R2 data byte", rx_byte, e[7:0]);
          chk(rx_frame_err === e[8], "R5 R6 frame error flag", rx_frame_err, e[8]);
        end
        held_byte = rx_byte;
      end
      prev_done = rx_done;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int g0, d0;
    repeat (5) @(posedge clk);
    #1;
    chk(rx_byte == 8'h00 && !rx_done && !rx_frame_err && !rx_glitch,
        "R1 outputs during reset", {rx_byte, rx_done, rx_frame_err, rx_glitch}, 0);
    @(posedge clk);
    rst <= 1'b0;
    @(negedge clk);
    chk(rx_byte == 8'h00 && !rx_done && !rx_frame_err && !rx_glitch,
        "R1 outputs after reset", {rx_byte, rx_done, rx_frame_err, rx_glitch}, 0);
    line_for(1'b1, 20);

    // R2: several data patterns
    send_frame(8'h55, 1'b1);
    line_for(1'b1, 30);
    send_frame(8'hA3, 1'b1);
    line_for(1'b1, 30);
    send_frame(8'hFF, 1'b1);
    line_for(1'b1, 30);
    send_frame(8'h01, 1'b1);
    line_for(1'b1, 30);
    send_frame(8'h80, 1'b1);
    line_for(1'b1, 30);

    // R5: corrupted stop bit, then R6: a good frame clears the flag
    send_frame(8'h3C, 1'b0);
    line_for(1'b1, 2 * CPB);
    chk(rx_frame_err === 1'b1, "R6 flag held after done", rx_frame_err, 1);
    send_frame(8'h96, 1'b1);
    line_for(1'b1, 30);

    // R7: short low glitch
    g0 = glitch_cnt;
    d0 = done_cnt;
    line_for(1'b0, 10);
    line_for(1'b1, 2 * CPB);
    chk(glitch_cnt == g0 + 1, "R7 glitch pulse", glitch_cnt - g0, 1);
    chk(done_cnt == d0, "R7 no done on glitch", done_cnt - d0, 0);
    chk(rx_byte === 8'h96, "R7 byte unchanged", rx_byte, 8'h96);

    // R8: back-to-back frames
    d0 = done_cnt;
    send_frame(8'h5A, 1'b1);
    send_frame(8'hC3, 1'b1);
    send_frame(8'h0F, 1'b1);
    line_for(1'b1, 2 * CPB);
    chk(done_cnt == d0 + 3, "R8 back-to-back count", done_cnt - d0, 3);

    // R9: line held low for three frame times
    d0 = done_cnt;
    exp_q.push_back({1'b1, 8'h00});
    line_for(1'b0, 30 * CPB);
    line_for(1'b1, 3 * CPB);
    chk(done_cnt == d0 + 1, "R9 single frame from stuck low", done_cnt - d0, 1);
    chk(rx_frame_err === 1'b1, "R9 stuck low flags framing", rx_frame_err, 1);

    chk(exp_q.size() == 0, "R2 all expected frames delivered", exp_q.size(), 0);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule